// File: doc/BRIEF.md
# UART Transmit Steering with RS485 Direction Output

This block sits between the host write port of a UART and its transmit shift register. Each byte the host writes is steered either into the transmit FIFO or straight toward the shift register. A one-shot "send now" control, when armed with the FIFO in use, sends exactly the next written byte past the queue. The control disarms itself once that byte has left the wire. If the shifter is busy when such a byte arrives, a one-entry holding register keeps it and gives it priority over queued FIFO data. The block also feeds the shifter from the FIFO head and pops the FIFO as it does so.

The block also drives an active-low direction line for RS485 half-duplex transceivers. The line is at its transmit level from the moment data is pending until the last stop bit ends. A polarity control swaps the transmit and receive levels. With RS485 mode off, the line rests high. The FIFO storage and the bit-serial shifter sit outside this block.

Top module: `uart_tx_steer`

## Requirements
- R1: After reset, `shf_load`, `fifo_push` and `imm_active` are 0 and `rts_n` is 1.
- R2: With `fifo_en`=1 and no send-now armed, each write asserts `fifo_push` in the write cycle with `fifo_push_data`=`wr_data`. Queued bytes reach the shifter in write order, each one popped from the FIFO head.
- R3: A `imm_set` pulse with `fifo_en`=1 raises `imm_active` one cycle later. The next write is then not pushed. If the shifter is idle, `shf_load` rises the cycle after the write, with that byte on `shf_data`.
- R4: Only one byte passes the queue for each `imm_set`. A write made after the bypassed byte was taken goes to the FIFO.
- R5: `imm_active` stays 1 through the `shf_done` pulse that ends the bypassed byte and reads 0 in the following cycle.
- R6: A bypass byte written while the shifter is busy is held. It is loaded as soon as the shifter is free, before any byte still waiting in the FIFO.
- R7: With `fifo_en`=0, `fifo_push` stays 0 and every write goes to the shifter in write order: directly if the shifter is free, else through the holding register. An `imm_set` pulse leaves `imm_active` at 0.
- R8: With `rs485_en`=1 and `rts_inv`=0, `rts_n` is 0 while the shifter is busy and 1 once the block has been idle for two cycles.
- R9: With `rs485_en`=1 and `rts_inv`=1, `rts_n` is 1 while the shifter is busy and 0 once idle.
- R10: With `rs485_en`=0, `rts_n` is 1 even while transmitting.
- R11: `shf_load` is a one-cycle pulse and is never asserted while `shf_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host writes a transmit byte this cycle |
| wr_data | input | DATA_W | Byte written by the host |
| fifo_en | input | 1 | Transmit FIFO in use |
| imm_set | input | 1 | One-cycle pulse arming send-now for one byte |
| rts_inv | input | 1 | Swap transmit and receive levels of `rts_n` |
| rs485_en | input | 1 | Enable RS485 direction control |
| shf_busy | input | 1 | Shift register is sending a byte |
| shf_done | input | 1 | One-cycle pulse when the last stop bit ends |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd_data | input | DATA_W | Byte at the FIFO head (show-ahead) |
| fifo_push | output | 1 | Write `fifo_push_data` into the FIFO |
| fifo_push_data | output | DATA_W | Byte to enqueue |
| fifo_pop | output | 1 | Remove the FIFO head; it is taken this cycle |
| shf_load | output | 1 | Load `shf_data` into the shift register |
| shf_data | output | DATA_W | Byte for the shift register |
| imm_active | output | 1 | Send-now control still set (self-clearing) |
| rts_n | output | 1 | Active-low direction line |

## Verification
The steering is exercised with four write patterns: plain queued writes on an idle line, a send-now write on an idle shifter, a send-now write behind a busy shifter with FIFO data waiting, and writes with the FIFO switched off. The first pattern shows that queueing keeps write order. The second separates direct loading from pushing, and the byte that follows it shows that the control expires after one use. The third shows that the holding register is served before the FIFO. The fourth confirms that the control is ignored and nothing is pushed. The direction line is observed idle and mid-frame under both polarities and with RS485 off, which tells a swapped polarity apart from a line that never moves.

// File: rtl/uts_pkg.sv
package uts_pkg;
   typedef enum logic [1:0] {
      IMM_IDLE    = 2'd0,
      IMM_ARMED   = 2'd1,
      IMM_HELD    = 2'd2,
      IMM_SENDING = 2'd3
   } imm_state_e;
endpackage

// File: rtl/uts_imm_ctl.sv
module uts_imm_ctl
   import uts_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic fifo_en_i,
   input  logic wr_taken_i,
   input  logic tag_load_i,
   input  logic shf_done_i,
   output logic armed_o,
   output logic status_o
);
   imm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         IMM_IDLE:    if (set_i && fifo_en_i) state_d = IMM_ARMED;
         IMM_ARMED: begin
            if (!fifo_en_i)      state_d = IMM_IDLE;
            else if (wr_taken_i) state_d = tag_load_i ? IMM_SENDING : IMM_HELD;
         end
         IMM_HELD:    if (tag_load_i) state_d = IMM_SENDING;
         IMM_SENDING: if (shf_done_i) state_d = IMM_IDLE;
         default:     state_d = IMM_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= IMM_IDLE;
      else        state_q <= state_d;
   end

   assign armed_o  = (state_q == IMM_ARMED) && fifo_en_i;
   assign status_o = (state_q != IMM_IDLE);

   // R3: the control only rises after an arming pulse
   assert_rise_on_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o) |-> $past(set_i));
   // R5: it only clears after a finished frame or with the FIFO switched off
   assert_clear_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o) |-> ($past(shf_done_i) || !$past(fifo_en_i)));
endmodule

// File: rtl/uts_load_arb.sv
module uts_load_arb #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              direct_i,
   input  logic              tag_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              fifo_en_i,
   input  logic              fifo_empty_i,
   input  logic [DATA_W-1:0] fifo_rd_data_i,
   input  logic              shf_busy_i,
   output logic              fifo_pop_o,
   output logic              shf_load_o,
   output logic [DATA_W-1:0] shf_data_o,
   output logic              wr_taken_o,
   output logic              tag_load_o,
   output logic              pend_o
);
   logic              hold_vld_q, hold_tag_q, ld_q;
   logic [DATA_W-1:0] hold_data_q, ld_data_q;
   logic              free, pick_hold, pick_wr, pick_fifo, to_hold;

   always_comb begin
      free      = !shf_busy_i && !ld_q;
      pick_hold = free && hold_vld_q;
      pick_wr   = free && !hold_vld_q && direct_i;
      pick_fifo = free && !hold_vld_q && !direct_i && fifo_en_i && !fifo_empty_i;
      to_hold   = direct_i && !pick_wr && (!hold_vld_q || pick_hold);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_q       <= 1'b0;
         ld_data_q  <= '0;
         hold_vld_q <= 1'b0;
         hold_tag_q <= 1'b0;
         hold_data_q <= '0;
      end else begin
         ld_q <= pick_hold || pick_wr || pick_fifo;
         if (pick_hold)      ld_data_q <= hold_data_q;
         else if (pick_wr)   ld_data_q <= wr_data_i;
         else if (pick_fifo) ld_data_q <= fifo_rd_data_i;
         if (to_hold) begin
            hold_vld_q  <= 1'b1;
            hold_tag_q  <= tag_i;
            hold_data_q <= wr_data_i;
         end else if (pick_hold) begin
            hold_vld_q <= 1'b0;
         end
      end
   end

   assign fifo_pop_o = pick_fifo;
   assign shf_load_o = ld_q;
   assign shf_data_o = ld_data_q;
   assign wr_taken_o = pick_wr || to_hold;
   assign tag_load_o = (pick_hold && hold_tag_q) || (pick_wr && tag_i);
   assign pend_o     = hold_vld_q || ld_q;

   // R6: a held byte reaches the shifter on the first free cycle
   assert_hold_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_vld_q && !shf_busy_i && !ld_q) |=> (shf_load_o && shf_data_o == $past(hold_data_q)));
   // R11: never load a busy shifter
   assert_load_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      shf_load_o |-> !shf_busy_i);
   // R11: the load strobe lasts one cycle
   assert_load_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      shf_load_o |=> !shf_load_o);
endmodule

// File: rtl/uts_rts_drv.sv
module uts_rts_drv #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rs485_en_i,
   input  logic rts_inv_i,
   input  logic active_i,
   output logic rts_n_o
);
   logic rts_d;
   assign rts_d = !rs485_en_i ? 1'b1 : (active_i ? rts_inv_i : !rts_inv_i);

   generate
      if (REG_OUT) begin : g_reg
         logic rts_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rts_q <= 1'b1;
            else        rts_q <= rts_d;
         end
         assign rts_n_o = rts_q;

         // R10: RS485 off leaves the line high
         assert_rts_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rs485_en_i) |-> rts_n_o);
         // R8: normal polarity drives low during an active frame
         assert_rts_low_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rs485_en_i) && $past(active_i) && !$past(rts_inv_i)) |-> !rts_n_o);
      end else begin : g_comb
         assign rts_n_o = rts_d;
      end
   endgenerate
endmodule

// File: rtl/uart_tx_steer.sv
module uart_tx_steer #(
   parameter int DATA_W  = 8,
   parameter bit RTS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fifo_en,
   input  logic              imm_set,
   input  logic              rts_inv,
   input  logic              rs485_en,
   input  logic              shf_busy,
   input  logic              shf_done,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_rd_data,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_push_data,
   output logic              fifo_pop,
   output logic              shf_load,
   output logic [DATA_W-1:0] shf_data,
   output logic              imm_active,
   output logic              rts_n
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_tx_steer: DATA_W must lie in 5..9");
      end
   endgenerate

   logic armed, direct, wr_taken, tag_load, pend, tx_active;

   assign direct         = wr_valid && (!fifo_en || armed);
   assign fifo_push      = wr_valid && fifo_en && !armed;
   assign fifo_push_data = wr_data;
   assign tx_active      = shf_busy || pend || (fifo_en && !fifo_empty);

   uts_imm_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (imm_set),
      .fifo_en_i  (fifo_en),
      .wr_taken_i (wr_taken),
      .tag_load_i (tag_load),
      .shf_done_i (shf_done),
      .armed_o    (armed),
      .status_o   (imm_active)
   );

   uts_load_arb #(.DATA_W(DATA_W)) u_arb (
      .clk            (clk),
      .rst_n          (rst_n),
      .direct_i       (direct),
      .tag_i          (armed),
      .wr_data_i      (wr_data),
      .fifo_en_i      (fifo_en),
      .fifo_empty_i   (fifo_empty),
      .fifo_rd_data_i (fifo_rd_data),
      .shf_busy_i     (shf_busy),
      .fifo_pop_o     (fifo_pop),
      .shf_load_o     (shf_load),
      .shf_data_o     (shf_data),
      .wr_taken_o     (wr_taken),
      .tag_load_o     (tag_load),
      .pend_o         (pend)
   );

   uts_rts_drv #(.REG_OUT(RTS_REG)) u_rts (
      .clk        (clk),
      .rst_n      (rst_n),
      .rs485_en_i (rs485_en),
      .rts_inv_i  (rts_inv),
      .active_i   (tx_active),
      .rts_n_o    (rts_n)
   );
endmodule

// File: tb/uart_tx_steer_tb.sv
module uart_tx_steer_tb;
   localparam int W    = 8;
   localparam int BITS = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0, fifo_en = 1'b1, imm_set = 1'b0, rts_inv = 1'b0, rs485_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic shf_busy, shf_done, fifo_empty;
   logic [W-1:0] fifo_rd_data;
   logic fifo_push, fifo_pop, shf_load, imm_active, rts_n;
   logic [W-1:0] fifo_push_data, shf_data;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   uart_tx_steer #(.DATA_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .fifo_en(fifo_en), .imm_set(imm_set), .rts_inv(rts_inv), .rs485_en(rs485_en),
      .shf_busy(shf_busy), .shf_done(shf_done), .fifo_empty(fifo_empty),
      .fifo_rd_data(fifo_rd_data), .fifo_push(fifo_push), .fifo_push_data(fifo_push_data),
      .fifo_pop(fifo_pop), .shf_load(shf_load), .shf_data(shf_data),
      .imm_active(imm_active), .rts_n(rts_n)
   );

   // shifter model and load log
   logic [W-1:0] log_mem [32];
   int log_n;
   logic log_clr = 1'b0;
   int sh_cnt;
   always @(posedge clk) begin
      if (!rst_n || log_clr) log_n <= 0;
      else if (shf_load) begin
         log_mem[log_n[4:0]] <= shf_data;
         log_n <= log_n + 1;
      end
      if (!rst_n) begin
         shf_busy <= 1'b0; shf_done <= 1'b0; sh_cnt <= 0;
      end else begin
         shf_done <= 1'b0;
         if (shf_load) begin
            shf_busy <= 1'b1; sh_cnt <= BITS;
         end else if (shf_busy) begin
            if (sh_cnt == 1) begin shf_busy <= 1'b0; shf_done <= 1'b1; end
            sh_cnt <= sh_cnt - 1;
         end
      end
   end

   // FIFO model
   logic [W-1:0] fmem [16];
   logic [3:0] wp, rp;
   int fcnt;
   assign fifo_empty   = (fcnt == 0);
   assign fifo_rd_data = fmem[rp];
   always @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; fcnt <= 0;
      end else begin
         if (fifo_push) begin fmem[wp] <= fifo_push_data; wp <= wp + 1'b1; end
         if (fifo_pop) rp <= rp + 1'b1;
         fcnt <= fcnt + (fifo_push ? 1 : 0) - (fifo_pop ? 1 : 0);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input logic [W-1:0] d, output logic pushed);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = d;
      #1 pushed = fifo_push;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_set();
      @(negedge clk); imm_set = 1'b1;
      @(negedge clk); imm_set = 1'b0;
   endtask

   task automatic clr_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      for (int i = 0; i < 400 && q < 4; i++) begin
         @(negedge clk);
         if (!shf_busy && !shf_load && fifo_empty) q++; else q = 0;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 shf_load", shf_load, 0);
      chk("R1 fifo_push", fifo_push, 0);
      chk("R1 imm_active", imm_active, 0);
      chk("R1 rts_n", rts_n, 1);
   endtask

   task automatic t_queue();
      logic p;
      fifo_en = 1'b1;
      clr_log();
      wr_byte(8'hA1, p); chk("R2 push A1", p, 1);
      wr_byte(8'hA2, p); chk("R2 push A2", p, 1);
      wr_byte(8'hA3, p); chk("R2 push A3", p, 1);
      wait_quiet();
      chk("R2 count", log_n, 3);
      chk("R2 order0", log_mem[0], 8'hA1);
      chk("R2 order1", log_mem[1], 8'hA2);
      chk("R2 order2", log_mem[2], 8'hA3);
   endtask

   task automatic t_bypass();
      logic p;
      fifo_en = 1'b1;
      clr_log();
      pulse_set();
      chk("R3 armed", imm_active, 1);
      wr_byte(8'hB0, p);
      chk("R3 not pushed", p, 0);
      chk("R3 direct load", shf_load, 1);
      chk("R3 direct data", shf_data, 8'hB0);
      wr_byte(8'hB1, p);
      chk("R4 second write queued", p, 1);
      chk("R5 still set", imm_active, 1);
      for (int i = 0; i < 100 && !shf_done; i++) @(negedge clk);
      chk("R5 set at done", imm_active, 1);
      @(negedge clk);
      chk("R5 clear after done", imm_active, 0);
      wait_quiet();
      chk("R4 count", log_n, 2);
      chk("R4 order1", log_mem[1], 8'hB1);
   endtask

   task automatic t_held();
      logic p;
      fifo_en = 1'b1;
      clr_log();
      wr_byte(8'hC1, p);
      wr_byte(8'hC2, p);
      wr_byte(8'hC3, p);
      chk("R6 shifter busy", shf_busy, 1);
      pulse_set();
      wr_byte(8'hDD, p);
      chk("R6 held not pushed", p, 0);
      wait_quiet();
      chk("R6 count", log_n, 4);
      chk("R6 order0", log_mem[0], 8'hC1);
      chk("R6 held before fifo", log_mem[1], 8'hDD);
      chk("R6 order2", log_mem[2], 8'hC2);
      chk("R6 order3", log_mem[3], 8'hC3);
      chk("R5 cleared at end", imm_active, 0);
   endtask

   task automatic t_nofifo();
      logic p;
      fifo_en = 1'b0;
      clr_log();
      pulse_set();
      chk("R7 set ignored", imm_active, 0);
      wr_byte(8'hE1, p); chk("R7 no push E1", p, 0);
      wr_byte(8'hE2, p); chk("R7 no push E2", p, 0);
      wait_quiet();
      chk("R7 count", log_n, 2);
      chk("R7 order0", log_mem[0], 8'hE1);
      chk("R7 order1", log_mem[1], 8'hE2);
      fifo_en = 1'b1;
   endtask

   task automatic t_rts(input logic en, input logic inv, input logic tx_lvl, input logic rx_lvl,
                        input string req);
      logic p;
      rs485_en = en; rts_inv = inv;
      repeat (3) @(negedge clk);
      chk({req, " idle level"}, rts_n, rx_lvl);
      wr_byte(8'h5A, p);
      repeat (3) @(negedge clk);
      chk({req, " busy"}, shf_busy, 1);
      chk({req, " tx level"}, rts_n, tx_lvl);
      wait_quiet();
      repeat (2) @(negedge clk);
      chk({req, " back to rx"}, rts_n, rx_lvl);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_queue();
      t_bypass();
      t_held();
      t_nofifo();
      t_rts(1'b1, 1'b0, 1'b0, 1'b1, "R8");
      t_rts(1'b1, 1'b1, 1'b1, 1'b0, "R9");
      t_rts(1'b0, 1'b0, 1'b1, 1'b1, "R10");
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule